// File: doc/BRIEF.md
# DMA Completion Interrupt Moderator

This block sits between one direction of a DMA engine and the interrupt logic. Every completion from the engine arrives as a one-cycle pulse. Instead of raising an interrupt for each completion, the block holds the completions back and releases a single one-cycle done event. Two timers set when that happens. The burst timer caps how long the first held completion may wait. The idle timer fires when the completion stream has been quiet for a programmed gap. Each timer can count either clock cycles or pulses of an external microsecond tick.

Software programs the block through a small 32-bit register port with four words: a control word and a threshold word for each timer. Setting a control word's clear bit stops that timer and zeroes its count, so the timer can be reprogrammed safely. When both timers are disabled, the block passes each completion straight through as a done event. A separate risk output shows when completions are being held while the receive buffer reports that it is filling up. The consumer can then drain the buffer early.

The controller has three states. IDLE means nothing is held. HOLD means at least one completion is waiting. FIRE is the single cycle in which done is driven. The transitions are:
- IDLE to HOLD on a completion when either timer is enabled.
- IDLE to FIRE on a completion when both timers are disabled.
- HOLD to FIRE when a timer fires, or when both timers have been disabled.
- FIRE to HOLD on a completion when a timer is enabled.
- FIRE to FIRE on a completion when both timers are disabled.
- FIRE to IDLE otherwise.

Top module: `dma_irq_moderator`

## Requirements
- R1: After reset, done_o and risk_o are 0 and all four register words read as 0.
- R2: Register addresses map as follows. Address 0 is the burst control word, 1 the burst threshold, 2 the idle control word and 3 the idle threshold. In a control word, bit 0 enables the timer and bit 2 selects the external tick; both read back in place, and bit 1 always reads 0. A threshold word stores and returns only its low CNT_W bits, with the upper bits read as 0.
- R3: A control write with bit 1 set disables that timer, clears its tick select and zeroes its count, whatever the other bits hold. A timer re-enabled after such a clear therefore counts its full threshold again from 0.
- R4: With both timers disabled, done_o is 1 in the cycle after each edge that samples cmpl_i high; back-to-back completions give back-to-back done cycles.
- R5: With only the burst timer enabled and threshold T on the clock time base, done_o goes high after the (T+1)-th edge following the edge that captured the first held completion, for one cycle. Further completions while the completion is held do not move this point.
- R6: With only the idle timer enabled and threshold T, every completion restarts the count, and done_o goes high after the (T+1)-th edge following the last completion. While cmpl_i stays high, the idle timer never fires.
- R7: A timer with its external tick selected advances, and may fire, only on edges where usec_tick_i is high.
- R8: Whichever enabled timer fires first releases done_o for exactly one cycle, and both counts then restart. A completion sampled during the done cycle starts a new hold.
- R9: risk_o equals fill_high_i while a completion is held, and is 0 otherwise.
- R10: A threshold of 0 fires on the first tick after the completion, so done_o follows one edge after the capture edge when counting clock cycles.
- R11: Disabling both timers while a completion is held releases done_o after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_i | input | 1 | One-cycle DMA completion pulse |
| usec_tick_i | input | 1 | External microsecond tick, one cycle wide |
| fill_high_i | input | 1 | Receive buffer above its high-water level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for the word at reg_addr_i |
| done_o | output | 1 | Moderated completion event, one cycle |
| risk_o | output | 1 | Buffer overflow risk while completions are held |

## Verification
The assertions check four things on every cycle:
- completion pass-through when both timers are off;
- a done cycle always has a sampled completion or a hold behind it;
- done never lasts beyond one cycle unless a new completion arrives;
- a clear strobe zeroes and disables its timer, and a completion restarts the idle count.

Exact firing points cannot be checked by assertions, because they depend on programmed thresholds and tick timing. These include the (T+1)-edge latency of each timer, threshold zero, external-tick pacing, and release on disable. They are shown only by the bench's directed scenarios and by its cycle-by-cycle reference comparison under random traffic and random reprogramming.

// File: rtl/irqmod_pkg.sv
package irqmod_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_FIRE = 2'd2
    } mod_state_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CLR_BIT = 1;
    localparam int CTRL_EXT_BIT = 2;

    localparam int NUM_TIMERS = 2;
    localparam int TMR_BURST  = 0;
    localparam int TMR_IDLE   = 1;
endpackage

// File: rtl/irqmod_cfg.sv
module irqmod_cfg
    import irqmod_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en_i,
    input  logic [1:0]                           addr_i,
    input  logic [DATA_W-1:0]                    wdata_i,
    output logic [DATA_W-1:0]                    rdata_o,
    output logic [NUM_TIMERS-1:0]                en_o,
    output logic [NUM_TIMERS-1:0]                ext_o,
    output logic [NUM_TIMERS-1:0]                clr_o,
    output logic [NUM_TIMERS-1:0][CNT_W-1:0]     thr_o
);
    logic unused_wdata;
    assign unused_wdata = ^wdata_i[DATA_W-1:CNT_W];

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_word
        logic sel_ctrl;
        logic sel_thr;
        assign sel_ctrl = wr_en_i && (addr_i[1] == 1'(g)) && !addr_i[0];
        assign sel_thr  = wr_en_i && (addr_i[1] == 1'(g)) &&  addr_i[0];
        assign clr_o[g] = sel_ctrl && wdata_i[CTRL_CLR_BIT];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_o[g]  <= 1'b0;
                ext_o[g] <= 1'b0;
                thr_o[g] <= '0;
            end else begin
                if (sel_ctrl) begin
                    if (wdata_i[CTRL_CLR_BIT]) begin
                        en_o[g]  <= 1'b0;
                        ext_o[g] <= 1'b0;
                    end else begin
                        en_o[g]  <= wdata_i[CTRL_EN_BIT];
                        ext_o[g] <= wdata_i[CTRL_EXT_BIT];
                    end
                end
                if (sel_thr) begin
                    thr_o[g] <= wdata_i[CNT_W-1:0];
                end
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i[0]) begin
            rdata_o[CNT_W-1:0] = thr_o[addr_i[1]];
        end else begin
            rdata_o[CTRL_EN_BIT]  = en_o[addr_i[1]];
            rdata_o[CTRL_EXT_BIT] = ext_o[addr_i[1]];
        end
    end
endmodule

// File: rtl/irqmod_timer.sv
module irqmod_timer #(
    parameter int CNT_W           = 16,
    parameter bit RESTART_ON_CMPL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             ext_i,
    input  logic             usec_tick_i,
    input  logic [CNT_W-1:0] thr_i,
    input  logic             hold_i,
    input  logic             cmpl_i,
    input  logic             clr_i,
    output logic             fire_o,
    output logic [CNT_W-1:0] cnt_o
);
    logic advance;
    logic restart;

    assign advance = en_i && (ext_i ? usec_tick_i : 1'b1);
    assign restart = RESTART_ON_CMPL && cmpl_i;
    assign fire_o  = hold_i && advance && !restart && (cnt_o >= thr_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (!hold_i || clr_i || restart || fire_o) begin
            cnt_o <= '0;
        end else if (advance) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/irqmod_fsm.sv
module irqmod_fsm
    import irqmod_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmpl_i,
    input  logic any_en_i,
    input  logic fire_i,
    input  logic level_hi_i,
    output logic hold_o,
    output logic done_o,
    output logic risk_o
);
    mod_state_e state_q;
    mod_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmpl_i) begin
                    state_d = any_en_i ? ST_HOLD : ST_FIRE;
                end
            end
            ST_HOLD: begin
                if (!any_en_i || fire_i) begin
                    state_d = ST_FIRE;
                end
            end
            ST_FIRE: begin
                if (cmpl_i) begin
                    state_d = any_en_i ? ST_HOLD : ST_FIRE;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        hold_o = (state_q == ST_HOLD);
        done_o = (state_q == ST_FIRE);
        risk_o = (state_q == ST_HOLD) && level_hi_i;
    end
endmodule

// File: rtl/dma_irq_moderator.sv
module dma_irq_moderator
    import irqmod_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmpl_i,
    input  logic              usec_tick_i,
    input  logic              fill_high_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              done_o,
    output logic              risk_o
);
    logic [NUM_TIMERS-1:0]            tm_en;
    logic [NUM_TIMERS-1:0]            tm_ext;
    logic [NUM_TIMERS-1:0]            tm_clr;
    logic [NUM_TIMERS-1:0]            tm_fire;
    logic [NUM_TIMERS-1:0][CNT_W-1:0] tm_thr;
    logic [NUM_TIMERS-1:0][CNT_W-1:0] tm_cnt;
    logic                             holding;

    irqmod_cfg #(.CNT_W(CNT_W), .DATA_W(DATA_W)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .en_o    (tm_en),
        .ext_o   (tm_ext),
        .clr_o   (tm_clr),
        .thr_o   (tm_thr)
    );

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
        irqmod_timer #(
            .CNT_W           (CNT_W),
            .RESTART_ON_CMPL (g == TMR_IDLE)
        ) tmr_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .en_i        (tm_en[g]),
            .ext_i       (tm_ext[g]),
            .usec_tick_i (usec_tick_i),
            .thr_i       (tm_thr[g]),
            .hold_i      (holding),
            .cmpl_i      (cmpl_i),
            .clr_i       (tm_clr[g]),
            .fire_o      (tm_fire[g]),
            .cnt_o       (tm_cnt[g])
        );
    end

    irqmod_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmpl_i     (cmpl_i),
        .any_en_i   (|tm_en),
        .fire_i     (|tm_fire),
        .level_hi_i (fill_high_i),
        .hold_o     (holding),
        .done_o     (done_o),
        .risk_o     (risk_o)
    );
endmodule

// File: rtl/dma_irq_moderator_chk.sv
module dma_irq_moderator_chk #(
    parameter int CNT_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmpl_i,
    input logic                  done_o,
    input logic                  holding,
    input logic [1:0]            en,
    input logic [1:0]            clr,
    input logic [1:0][CNT_W-1:0] cnt
);
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_i && en == 2'b00) |=> done_o); // R4

    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(cmpl_i) || $past(holding))); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cmpl_i) |=> !done_o); // R8

    AST_CLEAR_ZERO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        clr[0] |=> (cnt[0] == '0 && !en[0])); // R3

    AST_CLEAR_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr[1] |=> (cnt[1] == '0 && !en[1])); // R3

    AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_i |=> (cnt[1] == '0)); // R6
endmodule

bind dma_irq_moderator dma_irq_moderator_chk #(.CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmpl_i  (cmpl_i),
    .done_o  (done_o),
    .holding (holding),
    .en      (tm_en),
    .clr     (tm_clr),
    .cnt     (tm_cnt)
);

// File: tb/dma_irq_moderator_tb_top.sv
`timescale 1ns/1ps
module dma_irq_moderator_tb_top;
    localparam int CNT_W = 16;
    localparam int WD_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmpl = 1'b0;
    logic        tick = 1'b0;
    logic        fill = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        done;
    logic        risk;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    dma_irq_moderator #(.CNT_W(CNT_W), .DATA_W(32)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmpl_i      (cmpl),
        .usec_tick_i (tick),
        .fill_high_i (fill),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .done_o      (done),
        .risk_o      (risk)
    );

    // Reference model: 0 = nothing held, 1 = held, 2 = done cycle
    int m_state;
    bit m_en [2];
    bit m_ext [2];
    int m_thr [2];
    int m_cnt [2];

    always @(posedge clk) begin : model
        bit any_on;
        bit fb;
        bit fi;
        int ns;
        int nc [2];
        int k;
        if (!rst_n) begin
            m_state = 0;
            for (int j = 0; j < 2; j++) begin
                m_en[j] = 0; m_ext[j] = 0; m_thr[j] = 0; m_cnt[j] = 0;
            end
        end else begin
            any_on = m_en[0] || m_en[1];
            fb = m_en[0] && (!m_ext[0] || tick) && (m_cnt[0] >= m_thr[0]);
            fi = m_en[1] && (!m_ext[1] || tick) && !cmpl && (m_cnt[1] >= m_thr[1]);
            ns = m_state;
            nc[0] = 0; nc[1] = 0;
            if (m_state == 0) begin
                if (cmpl) ns = any_on ? 1 : 2;
            end else if (m_state == 1) begin
                if (!any_on || fb || fi) begin
                    ns = 2;
                end else begin
                    nc[0] = m_cnt[0] + ((m_en[0] && (!m_ext[0] || tick)) ? 1 : 0);
                    nc[1] = cmpl ? 0 : m_cnt[1] + ((m_en[1] && (!m_ext[1] || tick)) ? 1 : 0);
                end
            end else begin
                ns = cmpl ? (any_on ? 1 : 2) : 0;
            end
            if (wr) begin
                k = addr[1];
                if (addr[0]) begin
                    m_thr[k] = int'(wdata[CNT_W-1:0]);
                end else if (wdata[1]) begin
                    m_en[k] = 0; m_ext[k] = 0; nc[k] = 0;
                end else begin
                    m_en[k] = wdata[0]; m_ext[k] = wdata[2];
                end
            end
            m_state = ns;
            m_cnt[0] = nc[0];
            m_cnt[1] = nc[1];
        end
    end

    function automatic logic [31:0] exp_rdata(input logic [1:0] a);
        logic [31:0] v = 32'd0;
        if (a[0]) v = 32'(m_thr[a[1]]);
        else v = {29'd0, m_ext[a[1]], 1'b0, m_en[a[1]]};
        return v;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        chk(cur_req, "model done", {31'd0, done}, {31'd0, m_state == 2});
        chk(cur_req, "model risk", {31'd0, risk}, {31'd0, (m_state == 1) && fill});
        chk(cur_req, "model rdata", rdata, exp_rdata(addr));
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        cyc();
        wr = 1'b0;
    endtask

    task automatic pulse();
        cmpl = 1'b1;
        cyc();
        cmpl = 1'b0;
    endtask

    task automatic quiesce();
        wreg(2'd0, 32'h2);
        wreg(2'd2, 32'h2);
        cyc(); cyc();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(WD_CYCLES * 5.0);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        int n;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        cur_req = "R1";
        fill = 1'b1;
        #1;
        chk("R1", "done after reset", {31'd0, done}, 32'd0);
        chk("R1", "risk after reset", {31'd0, risk}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            addr = 2'(a);
            #1 chk("R1", "reg after reset", rdata, 32'd0);
        end
        fill = 1'b0;
        addr = 2'd0;

        // R2 register map and readback
        cur_req = "R2";
        wreg(2'd0, 32'h0000_0005);
        chk("R2", "burst ctrl readback", rdata, 32'h5);
        wreg(2'd1, 32'hABCD_0007);
        chk("R2", "burst thr low bits", rdata, 32'h7);
        wreg(2'd3, 32'hFFFF_0009);
        chk("R2", "idle thr low bits", rdata, 32'h9);
        wreg(2'd2, 32'h0000_0001);
        chk("R2", "idle ctrl readback", rdata, 32'h1);

        // R3 clear wins over enable bits
        cur_req = "R3";
        wreg(2'd0, 32'h0000_0007);
        chk("R3", "clear disables ctrl", rdata, 32'h0);
        quiesce();

        // R4 pass-through
        cur_req = "R4";
        pulse();
        chk("R4", "single pass-through", {31'd0, done}, 32'd1);
        cyc();
        chk("R4", "pass-through drops", {31'd0, done}, 32'd0);
        cmpl = 1'b1;
        cyc();
        chk("R4", "back-to-back first", {31'd0, done}, 32'd1);
        cyc();
        cmpl = 1'b0;
        chk("R4", "back-to-back second", {31'd0, done}, 32'd1);
        cyc();
        chk("R4", "back-to-back end", {31'd0, done}, 32'd0);

        // R5 burst timer, T = 3, extra completion mid-hold
        cur_req = "R5";
        wreg(2'd1, 32'd3);
        wreg(2'd0, 32'h1);
        pulse();
        chk("R5", "held at capture", {31'd0, done}, 32'd0);
        cyc();
        chk("R5", "held edge 1", {31'd0, done}, 32'd0);
        pulse();
        chk("R5", "held edge 2", {31'd0, done}, 32'd0);
        cyc();
        chk("R5", "held edge 3", {31'd0, done}, 32'd0);
        cyc();
        chk("R5", "release edge 4", {31'd0, done}, 32'd1);
        cyc();
        chk("R5", "one cycle only", {31'd0, done}, 32'd0);

        // R10 zero threshold
        cur_req = "R10";
        wreg(2'd1, 32'd0);
        pulse();
        chk("R10", "held at capture", {31'd0, done}, 32'd0);
        cyc();
        chk("R10", "fires next edge", {31'd0, done}, 32'd1);
        quiesce();

        // R6 idle timer, T = 2
        cur_req = "R6";
        wreg(2'd3, 32'd2);
        wreg(2'd2, 32'h1);
        pulse();
        cyc();
        pulse();
        cyc();
        chk("R6", "restart edge+1", {31'd0, done}, 32'd0);
        cyc();
        chk("R6", "restart edge+2", {31'd0, done}, 32'd0);
        cyc();
        chk("R6", "restart edge+3", {31'd0, done}, 32'd1);
        cyc();
        wreg(2'd3, 32'd0);
        cmpl = 1'b1;
        n = 0;
        for (int i = 0; i < 10; i++) begin
            cyc();
            if (done && i > 0) n++;
        end
        cmpl = 1'b0;
        chk("R6", "no fire under steady stream", 32'(n), 32'd0);
        cyc();
        chk("R6", "fires after stream ends", {31'd0, done}, 32'd1);
        quiesce();

        // R7 external tick
        cur_req = "R7";
        wreg(2'd1, 32'd1);
        wreg(2'd0, 32'h5);
        pulse();
        n = 0;
        for (int i = 0; i < 5; i++) begin
            cyc();
            if (done) n++;
        end
        chk("R7", "no advance without tick", 32'(n), 32'd0);
        tick = 1'b1;
        cyc();
        chk("R7", "first tick counts", {31'd0, done}, 32'd0);
        cyc();
        tick = 1'b0;
        chk("R7", "second tick fires", {31'd0, done}, 32'd1);
        quiesce();

        // R9 risk, then R11 release on disable
        cur_req = "R9";
        wreg(2'd1, 32'd50);
        wreg(2'd0, 32'h1);
        fill = 1'b1;
        #1 chk("R9", "risk low when idle", {31'd0, risk}, 32'd0);
        pulse();
        chk("R9", "risk while held", {31'd0, risk}, 32'd1);
        fill = 1'b0;
        #1 chk("R9", "risk follows level", {31'd0, risk}, 32'd0);
        cur_req = "R11";
        wreg(2'd0, 32'h2);
        chk("R11", "still held at write edge", {31'd0, done}, 32'd0);
        cyc();
        chk("R11", "released after disable", {31'd0, done}, 32'd1);
        quiesce();

        // R3 clear restarts the count
        cur_req = "R3";
        wreg(2'd3, 32'd100);
        wreg(2'd2, 32'h1);
        wreg(2'd1, 32'd4);
        wreg(2'd0, 32'h1);
        pulse();
        cyc(); cyc();
        wreg(2'd0, 32'h3);
        wreg(2'd0, 32'h1);
        n = 0;
        for (int i = 1; i <= 20; i++) begin
            cyc();
            if (done) begin n = i; break; end
        end
        chk("R3", "full count after clear", 32'(n), 32'd5);
        quiesce();

        // R8 random traffic and reprogramming
        cur_req = "R8";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 39) == 0) begin
                wr = 1'b1;
                addr = 2'($urandom_range(0, 3));
                wdata = addr[0] ? 32'($urandom_range(0, 6)) : 32'($urandom_range(0, 7));
            end else begin
                wr = 1'b0;
                addr = 2'($urandom_range(0, 3));
            end
            cmpl = ($urandom_range(0, 3) == 0);
            tick = ($urandom_range(0, 2) == 0);
            fill = $urandom_range(0, 1) == 1;
            cyc();
        end
        wr = 1'b0; cmpl = 1'b0; tick = 1'b0; fill = 1'b0;
        cyc();
        finish_run();
    end
endmodule